// File: doc/BRIEF.md
# Iterative GCD Unit

This block finds the greatest common divisor of two unsigned integers by a repeated exchange-and-subtract loop, one step per clock cycle. A producer offers an operand pair on a valid/ready input port. The unit accepts one pair, iterates until its second working register reaches zero, and then presents the first working register as the result on a valid/ready output port. It holds that result until the consumer takes it.

A small controller steers a datapath of two enabled registers. The first register loads from a three-way select: the incoming operand, the other register, or the difference. The second register loads from a two-way select: the incoming operand or the first register. The datapath returns two status flags to the controller: "first below second" and "second is zero". In each computing cycle the controller makes one choice. When the first value is below the second, both registers exchange in the same cycle. Otherwise, when the second value is nonzero, the first register takes the difference. Otherwise the unit finishes.

Only one request is in flight at a time. Back-pressure works in both directions. While a pair is being computed, or while a result is waiting to be taken, the input port is not ready. A result stays valid and unchanged for as long as the consumer holds ready low.

Top module: `gcd_unit`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `out_valid` is 0 and `in_ready` is 1.
- R2: A pair is accepted only at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the result has been taken, and `in_valid` or operand changes during that time have no effect on the result.
- R3: The delivered `out_data` equals the greatest common divisor of the accepted pair, with gcd(0,x)=x, gcd(x,0)=x and gcd(0,0)=0.
- R4: While `out_valid` is 1 and `out_ready` is 0, both `out_valid` and `out_data` hold their values into the next cycle.
- R5: After an edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1 in the next cycle.
- R6: `in_ready` and `out_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers an operand pair |
| in_ready | output | 1 | Unit is idle and will take a pair |
| in_a | input | W | First operand, unsigned |
| in_b | input | W | Second operand, unsigned |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Greatest common divisor |

## Verification
The assertions assume that the consumer does not require `out_data` before `out_valid` is first raised. They also assume that reset is held for at least one edge before any handshake takes place. The bench applies reset for several cycles and then sweeps every operand pair of a 5-bit instance, including all pairs that contain zero. It keeps `in_valid` high with changed operands while the unit is busy, to show that the input is ignored. It also delays `out_ready` by a varying number of cycles to apply back-pressure. Each result is compared with a Euclid reference computed in the bench.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2
  } gcd_state_e;

  typedef enum logic [1:0] {
    ASEL_LOAD = 2'd0,
    ASEL_PEER = 2'd1,
    ASEL_DIFF = 2'd2
  } a_sel_e;

  typedef enum logic {
    BSEL_LOAD = 1'b0,
    BSEL_PEER = 1'b1
  } b_sel_e;
endpackage

// File: rtl/gcd_en_reg.sv
module gcd_en_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (en) q <= d;
  end
endmodule

// File: rtl/gcd_dpath.sv
module gcd_dpath
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         a_en,
  input  logic         b_en,
  input  a_sel_e       a_sel,
  input  b_sel_e       b_sel,
  output logic         b_zero,
  output logic         a_lt_b,
  output logic [W-1:0] result
);
  logic [W-1:0] a_q, b_q, a_d, b_d, diff;

  assign diff = a_q - b_q;

  always_comb begin
    unique case (a_sel)
      ASEL_PEER: a_d = b_q;
      ASEL_DIFF: a_d = diff;
      default:   a_d = in_a;
    endcase
  end

  assign b_d = (b_sel == BSEL_PEER) ? a_q : in_b;

  gcd_en_reg #(.W(W)) a_reg_i (.clk(clk), .en(a_en), .d(a_d), .q(a_q));
  gcd_en_reg #(.W(W)) b_reg_i (.clk(clk), .en(b_en), .d(b_d), .q(b_q));

  assign b_zero = (b_q == '0);
  assign a_lt_b = (a_q < b_q);
  assign result = a_q;
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   in_valid,
  input  logic   out_ready,
  input  logic   b_zero,
  input  logic   a_lt_b,
  output logic   in_ready,
  output logic   out_valid,
  output logic   a_en,
  output logic   b_en,
  output a_sel_e a_sel,
  output b_sel_e b_sel
);
  gcd_state_e st, st_nxt;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  always_comb begin
    st_nxt = st;
    a_en   = 1'b0;
    b_en   = 1'b0;
    a_sel  = ASEL_LOAD;
    b_sel  = BSEL_LOAD;
    unique case (st)
      ST_IDLE: if (in_valid) begin
        a_en   = 1'b1;
        b_en   = 1'b1;
        st_nxt = ST_CALC;
      end
      ST_CALC: begin
        if (a_lt_b) begin
          a_en  = 1'b1;
          b_en  = 1'b1;
          a_sel = ASEL_PEER;
          b_sel = BSEL_PEER;
        end else if (!b_zero) begin
          a_en  = 1'b1;
          a_sel = ASEL_DIFF;
        end else begin
          st_nxt = ST_DONE;
        end
      end
      ST_DONE: if (out_ready) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_DONE);
endmodule

// File: rtl/gcd_unit.sv
module gcd_unit
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic   a_en, b_en, b_zero, a_lt_b;
  a_sel_e a_sel;
  b_sel_e b_sel;

  gcd_ctrl ctrl_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .b_zero(b_zero), .a_lt_b(a_lt_b), .in_ready(in_ready),
    .out_valid(out_valid), .a_en(a_en), .b_en(b_en),
    .a_sel(a_sel), .b_sel(b_sel)
  );

  gcd_dpath #(.W(W)) dpath_i (
    .clk(clk), .in_a(in_a), .in_b(in_b), .a_en(a_en), .b_en(b_en),
    .a_sel(a_sel), .b_sel(b_sel), .b_zero(b_zero), .a_lt_b(a_lt_b),
    .result(out_data)
  );
endmodule

// File: rtl/gcd_unit_chk.sv
module gcd_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_hold_result_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
endmodule

bind gcd_unit gcd_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/gcd_unit_tb_top.sv
module gcd_unit_tb_top;
  localparam int W = 5;
  localparam int N = 1 << W;
  localparam int LIMIT = 190000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  gcd_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic int ref_gcd(int x, int y);
    int t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_pair(int a, int b);
    int exp = ref_gcd(a, b);
    int wait_n = 0;
    int delay = (a + 2 * b) % 4;
    @(negedge clk);
    in_valid = 1'b1;
    in_a = W'(a);
    in_b = W'(b);
    @(negedge clk);
    // R2: busy after acceptance; disturb inputs, which must be ignored
    check(!in_ready, "R2 busy", int'(in_ready), 0);
    in_a = W'(~a);
    in_b = W'(b + 3);
    while (!out_valid && wait_n < 200) begin
      check(!in_ready, "R6 no ready while computing", int'(in_ready), 0);
      @(negedge clk);
      wait_n++;
    end
    check(out_valid, "R3 result arrives", int'(out_valid), 1);
    check(int'(out_data) == exp, "R3 gcd value", int'(out_data), exp);
    check(!in_ready, "R6 exclusive", int'(in_ready), 0);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      check(out_valid && int'(out_data) == exp, "R4 hold under back-pressure",
            int'(out_data), exp);
    end
    out_ready = 1'b1;
    in_valid  = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R5 release",
          int'({out_valid, in_ready}), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!out_valid && in_ready, "R1 reset", int'({out_valid, in_ready}), 1);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 idle after reset",
          int'({out_valid, in_ready}), 1);
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        run_pair(a, b);
      end
    end
    finish_run();
  end

  initial begin
    wait (cycles >= LIMIT);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
    finish_run();
  end
endmodule